// File: doc/BRIEF.md
# Cascadable Two-Wire Serial Memory Slave

This block is the slave side of a two-wire serial link in front of a byte-wide register-file memory of 2048 locations. The SCL and SDA lines come in asynchronously and are oversampled by the system clock. The block finds START and STOP conditions, and receives the first byte of each transfer. That byte selects one of up to eight cascaded slaves through three strap inputs and also carries the upper three bits of the 11-bit word address. The block then performs writes, reads from the current address, random reads and sequential reads.

SDA is driven only as an open-drain pull-down enable. A write-protect input blocks every update to the array. The bus transfer continues normally while it is set, so a master sees the same acknowledge sequence whether protection is on or off.

Top module: `tw_mem_slave`

## Requirements
- R1: After synchronous reset the slave is idle and the pull-down enable `sda_oe_o` is 0, so SDA is released.
- R2: A START is a falling SDA while SCL is high, and a STOP is a rising SDA while SCL is high. Until a START has been seen, clocked bytes are ignored and never acknowledged.
- R3: The first byte after a START is a match only when bit 7 is 1, bit 6 equals strap A2, bit 5 equals the inverse of strap A1 and bit 4 equals strap A0, with `strap_i` = {A2, A1, A0}. On a match the slave pulls SDA low through the whole 9th SCL high phase. On a mismatch it does not acknowledge and ignores all later bytes until the next START.
- R4: Bits 3..1 of the first byte become word-address bits 10..8. Bit 0 selects the direction, where 1 is read and 0 is write. The bits are taken in both directions.
- R5: In a write, the second byte sets word-address bits 7..0 and is acknowledged. Each later byte is acknowledged, stored at the current address, and the address then increments by one.
- R6: While `wp_i` is 1, data bytes are still acknowledged but the array is left unchanged.
- R7: In a read, each byte is sent MSB first on SCL falling edges, and SDA is released during the 9th clock. A master acknowledge (SDA low on the 9th clock) makes the slave send the byte at the next address. A master no-acknowledge returns the slave to idle with SDA released.
- R8: The word address advances modulo 2048, so a sequential read continues from address 2047 to address 0.
- R9: A repeated START at any point restarts the bit count and returns the slave to decoding a first byte. This makes a random read possible: a write header, the low address, a repeated START and a read header.
- R10: A STOP at any point returns the slave to idle and releases SDA.
- R11: The pull-down enable changes only while SCL is low, after a falling SCL edge has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| strap_i | input | 3 | Cascade strap inputs {A2, A1, A0} |
| wp_i | input | 1 | Write protect; 1 blocks array updates |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |

## Verification
The hardest situations to reach from the ports are the address roll-over from 2047 to 0 in the middle of a sequential read, and a read from the current address whose start point was left behind by an earlier transfer. The stimulus first fills the top and bottom of the array. It then issues a random read that crosses the boundary and, straight after it, a current-address read whose expected data follow only from where the previous read stopped. A full sweep of all strap values against all device-select codes covers the inverted strap bit, and the bytes that follow a mismatch show that the slave stays silent.

// File: rtl/tw_mem_pkg.sv
package tw_mem_pkg;

   // Protocol phases of the slave
   typedef enum logic [2:0] {
      ST_IDLE,    // waiting for START
      ST_DEV,     // receiving first (select) byte
      ST_WADDR,   // receiving low word address
      ST_WDATA,   // receiving write data
      ST_ACK,     // slave drives acknowledge bit
      ST_RDATA,   // slave shifts out read data
      ST_RACK     // master acknowledge bit of a read
   } tw_state_e;

endpackage

// File: rtl/tw_sync_edge.sv
module tw_sync_edge #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic lvl,
   output logic prev
);

   logic [STAGES:0] chain;

   always_ff @(posedge clk) begin
      if (rst) chain <= {(STAGES + 1){RST_VAL}};
      else     chain <= {chain[STAGES-1:0], din};
   end

   assign lvl  = chain[STAGES-1];
   assign prev = chain[STAGES];

endmodule

// File: rtl/tw_mem_array.sv
module tw_mem_array #(
   parameter int AW = 11,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);

   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
   end

   assign rdata = mem[addr];

endmodule

// File: rtl/tw_mem_slave.sv
module tw_mem_slave
   import tw_mem_pkg::*;
#(
   parameter int         ADDR_W      = 11,
   parameter int         DATA_W      = 8,
   parameter int         SYNC_STAGES = 2,
   parameter logic [2:0] STRAP_INV   = 3'b010
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic [2:0] strap_i,
   input  logic       wp_i,
   output logic       sda_oe_o
);

   localparam int HI_W  = ADDR_W - DATA_W;
   localparam int CNT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] BYTE_BITS = DATA_W[CNT_W-1:0];

   generate
      if (DATA_W != 8) begin : g_bad_data
         $error("tw_mem_slave: DATA_W must be 8");
      end
      if (HI_W != 3) begin : g_bad_addr
         $error("tw_mem_slave: ADDR_W must be DATA_W + 3");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("tw_mem_slave: SYNC_STAGES must be at least 2");
      end
   endgenerate

   // Line synchronisers: index 1 = SCL, index 0 = SDA
   logic [1:0] raw_lines, lvl, prev;
   assign raw_lines = {scl_i, sda_i};

   for (genvar g = 0; g < 2; g++) begin : g_sync
      tw_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
         .clk (clk),
         .rst (rst),
         .din (raw_lines[g]),
         .lvl (lvl[g]),
         .prev(prev[g])
      );
   end

   logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;
   assign scl_s    = lvl[1];
   assign sda_s    = lvl[0];
   assign scl_rise =  scl_s & ~prev[1];
   assign scl_fall = ~scl_s &  prev[1];
   assign start_c  =  scl_s & prev[1] &  prev[0] & ~sda_s;
   assign stop_c   =  scl_s & prev[1] & ~prev[0] &  sda_s;

   tw_state_e         state, after;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] sh;
   logic [ADDR_W-1:0] addr;
   logic              mack;
   logic              oe;
   logic              dev_hit;
   logic              mem_we;
   logic [DATA_W-1:0] mem_rdata;

   assign dev_hit = sh[DATA_W-1] && (sh[DATA_W-2 -: 3] == (strap_i ^ STRAP_INV));
   assign mem_we  = (state == ST_WDATA) && scl_fall && (cnt == BYTE_BITS) && !wp_i;

   tw_mem_array #(.AW(ADDR_W), .DW(DATA_W)) u_array (
      .clk  (clk),
      .we   (mem_we),
      .addr (addr),
      .wdata(sh),
      .rdata(mem_rdata)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= ST_IDLE;
         after <= ST_IDLE;
         cnt   <= '0;
         sh    <= '0;
         addr  <= '0;
         mack  <= 1'b0;
         oe    <= 1'b0;
      end else if (start_c) begin
         state <= ST_DEV;
         cnt   <= '0;
         oe    <= 1'b0;
      end else if (stop_c) begin
         state <= ST_IDLE;
         oe    <= 1'b0;
      end else begin
         case (state)
            ST_DEV, ST_WADDR, ST_WDATA: begin
               if (scl_rise) begin
                  sh  <= {sh[DATA_W-2:0], sda_s};
                  cnt <= cnt + 1'b1;
               end else if (scl_fall && cnt == BYTE_BITS) begin
                  cnt <= '0;
                  if (state == ST_DEV) begin
                     if (dev_hit) begin
                        addr[ADDR_W-1:DATA_W] <= sh[HI_W:1];
                        after <= sh[0] ? ST_RDATA : ST_WADDR;
                        oe    <= 1'b1;
                        state <= ST_ACK;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end else if (state == ST_WADDR) begin
                     addr[DATA_W-1:0] <= sh;
                     after <= ST_WDATA;
                     oe    <= 1'b1;
                     state <= ST_ACK;
                  end else begin
                     addr  <= addr + 1'b1;
                     after <= ST_WDATA;
                     oe    <= 1'b1;
                     state <= ST_ACK;
                  end
               end
            end
            ST_ACK: begin
               if (scl_fall) begin
                  cnt <= '0;
                  if (after == ST_RDATA) begin
                     sh   <= mem_rdata;
                     oe   <= ~mem_rdata[DATA_W-1];
                     addr <= addr + 1'b1;
                  end else begin
                     oe <= 1'b0;
                  end
                  state <= after;
               end
            end
            ST_RDATA: begin
               if (scl_rise) begin
                  cnt <= cnt + 1'b1;
               end else if (scl_fall) begin
                  if (cnt == BYTE_BITS) begin
                     oe    <= 1'b0;
                     cnt   <= '0;
                     state <= ST_RACK;
                  end else begin
                     sh <= {sh[DATA_W-2:0], 1'b0};
                     oe <= ~sh[DATA_W-2];
                  end
               end
            end
            ST_RACK: begin
               if (scl_rise) begin
                  mack <= ~sda_s;
               end else if (scl_fall) begin
                  if (mack) begin
                     sh    <= mem_rdata;
                     oe    <= ~mem_rdata[DATA_W-1];
                     addr  <= addr + 1'b1;
                     cnt   <= '0;
                     state <= ST_RDATA;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            ST_IDLE: ;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign sda_oe_o = oe;

endmodule

// File: rtl/tw_mem_slave_chk.sv
module tw_mem_slave_chk
   import tw_mem_pkg::*;
(
   input logic      clk,
   input logic      rst,
   input logic      wp_i,
   input logic      sda_oe_o,
   input logic      scl_fall,
   input logic      start_c,
   input logic      stop_c,
   input logic      mem_we,
   input tw_state_e state
);

   // R11: enable moves only one cycle after a seen SCL fall (or a bus condition)
   a_r11_oe_after_fall: assert property (@(posedge clk) disable iff (rst)
      !$stable(sda_oe_o) |-> $past(scl_fall || start_c || stop_c));

   // R10: STOP releases SDA and idles
   a_r10_stop_release: assert property (@(posedge clk) disable iff (rst)
      stop_c |=> (!sda_oe_o && state == ST_IDLE));

   // R9: START (first or repeated) returns to select-byte decode
   a_r9_start_decode: assert property (@(posedge clk) disable iff (rst)
      start_c |=> (state == ST_DEV && !sda_oe_o));

   // R6: write protect keeps the array write strobe low
   a_r6_wp_blocks: assert property (@(posedge clk) disable iff (rst)
      wp_i |-> !mem_we);

   // R5: a stored byte is followed by an acknowledge
   a_r5_write_acked: assert property (@(posedge clk) disable iff (rst)
      mem_we |=> (sda_oe_o && state == ST_ACK));

   // R7: SDA is pulled only in acknowledge or read-data phases
   a_r7_drive_phases: assert property (@(posedge clk) disable iff (rst)
      sda_oe_o |-> (state == ST_ACK || state == ST_RDATA));

endmodule

bind tw_mem_slave tw_mem_slave_chk u_chk (
   .clk     (clk),
   .rst     (rst),
   .wp_i    (wp_i),
   .sda_oe_o(sda_oe_o),
   .scl_fall(scl_fall),
   .start_c (start_c),
   .stop_c  (stop_c),
   .mem_we  (mem_we),
   .state   (state)
);

// File: tb/tw_mem_slave_tb.sv
module tw_mem_slave_tb_top;

   localparam int H     = 8;
   localparam int DEPTH = 2048;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic [2:0] strap = 3'b000;
   logic       wp = 1'b0;
   logic       sda_oe;
   logic       sda_line;

   int compared = 0;
   int mismatched = 0;
   int r11_bad = 0;
   bit done = 0;

   logic [7:0] model [DEPTH];

   always #5 clk = ~clk;

   assign sda_line = sda_m & ~sda_oe;

   tw_mem_slave dut_i (
      .clk     (clk),
      .rst     (rst),
      .scl_i   (scl_m),
      .sda_i   (sda_line),
      .strap_i (strap),
      .wp_i    (wp),
      .sda_oe_o(sda_oe)
   );

   // R11 monitor: the enable may only move while the bench holds SCL low
   logic oe_q = 1'b0;
   always @(negedge clk) begin
      if (!rst && sda_oe !== oe_q && scl_m !== 1'b0) r11_bad++;
      oe_q = sda_oe;
   end

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] devb(input logic [2:0] s, input logic [2:0] hi, input logic rd);
      return {1'b1, s[2], ~s[1], s[0], hi, rd};
   endfunction

   function automatic logic [7:0] pat(input int a, input int seed);
      return 8'((a * 37) + (a >> 5) + seed);
   endfunction

   task automatic clk_bit(input logic b, output logic seen);
      wait_n(2);
      sda_m = b;
      wait_n(H);
      scl_m = 1'b1;
      wait_n(H / 2);
      seen = sda_line;
      wait_n(H / 2);
      scl_m = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] d, output logic acked);
      logic s;
      for (int i = 7; i >= 0; i--) clk_bit(d[i], s);
      clk_bit(1'b1, s);
      acked = ~s;
   endtask

   task automatic read_byte(input logic give_ack, output logic [7:0] d);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         clk_bit(1'b1, s);
         d[i] = s;
      end
      clk_bit(~give_ack, s);
   endtask

   task automatic do_start;
      wait_n(2);
      sda_m = 1'b1;
      wait_n(H);
      scl_m = 1'b1;
      wait_n(H);
      sda_m = 1'b0;
      wait_n(H);
      scl_m = 1'b0;
   endtask

   task automatic do_stop;
      wait_n(2);
      sda_m = 1'b0;
      wait_n(H);
      scl_m = 1'b1;
      wait_n(H);
      sda_m = 1'b1;
      wait_n(H);
   endtask

   task automatic scl_low;
      wait_n(2);
      scl_m = 1'b0;
   endtask

   task automatic write_block(input int base, input int n, input int seed);
      logic a;
      logic [7:0] d;
      do_start;
      send_byte(devb(strap, 3'(base >> 8), 1'b0), a);
      chk("R4 write header ack", a, 1);
      send_byte(8'(base), a);
      chk("R5 low address ack", a, 1);
      for (int i = 0; i < n; i++) begin
         d = pat(base + i, seed);
         send_byte(d, a);
         chk(wp ? "R6 protected data ack" : "R5 data ack", a, 1);
         if (!wp) model[(base + i) % DEPTH] = d;
      end
      do_stop;
   endtask

   task automatic read_block(input int base, input int n, input bit random);
      logic a;
      logic [7:0] d;
      do_start;
      if (random) begin
         send_byte(devb(strap, 3'(base >> 8), 1'b0), a);
         chk("R9 random-read write header ack", a, 1);
         send_byte(8'(base), a);
         chk("R9 random-read address ack", a, 1);
         do_start;
      end
      send_byte(devb(strap, 3'(base >> 8), 1'b1), a);
      chk("R4 read header ack", a, 1);
      for (int i = 0; i < n; i++) begin
         read_byte(i != n - 1, d);
         chk(((base + i) % DEPTH == 0 && i > 0) ? "R8 wrapped read data" : "R7 read data",
             int'(d), int'(model[(base + i) % DEPTH]));
      end
      wait_n(4);
      chk("R7 released after master no-ack", int'(sda_oe), 0);
      do_stop;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         mismatched++;
         compared++;
         $display("FAIL watchdog R2-chain hung: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin : main
      logic a;
      logic [2:0] want;
      for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;

      wait_n(5);
      rst = 1'b0;
      wait_n(4);
      chk("R1 SDA released after reset", int'(sda_oe), 0);

      // R2: a matching byte without START is ignored
      strap = 3'b000;
      scl_low;
      send_byte(devb(3'b000, 3'b000, 1'b0), a);
      chk("R2 no ack without START", a, 0);
      do_stop;

      // R3: full sweep of strap values against select codes
      for (int s = 0; s < 8; s++) begin
         for (int d = 0; d < 8; d++) begin
            strap = 3'(s);
            want  = {strap[2], ~strap[1], strap[0]};
            wait_n(4);
            do_start;
            send_byte({1'b1, 3'(d), 3'b000, 1'b0}, a);
            chk("R3 select match ack", a, int'(3'(d) == want));
            if (3'(d) != want) begin
               send_byte(devb(strap, 3'b000, 1'b0), a);
               chk("R3 ignored after mismatch", a, 0);
            end
            do_stop;
         end
      end

      // R3: bit 7 clear never matches
      strap = 3'b011;
      do_start;
      send_byte({1'b0, strap[2], ~strap[1], strap[0], 4'b0000}, a);
      chk("R3 bit7 zero no ack", a, 0);
      do_stop;

      // R5/R4: writes in several banks, one crossing a high-bit boundary
      write_block(12'h000, 16, 3);
      write_block(12'h3F8, 16, 11);
      write_block(12'h7F8, 8, 29);

      // R9/R4: random reads back
      read_block(12'h3F8, 16, 1'b1);
      read_block(12'h005, 6, 1'b1);

      // R8: sequential read wraps 2047 -> 0, leaving address at 4
      read_block(12'h7FC, 8, 1'b1);
      // R7: current-address read continues from 4
      read_block(12'h004, 3, 1'b0);

      // R6: protected write leaves contents unchanged
      wp = 1'b1;
      write_block(12'h008, 4, 77);
      wp = 1'b0;
      read_block(12'h008, 4, 1'b1);

      // R10: STOP mid-transfer idles; following byte without START ignored
      do_start;
      send_byte(devb(strap, 3'b000, 1'b0), a);
      chk("R10 header ack", a, 1);
      send_byte(8'h20, a);
      chk("R10 address ack", a, 1);
      do_stop;
      chk("R10 SDA released after STOP", int'(sda_oe), 0);
      scl_low;
      send_byte(8'hA5, a);
      chk("R10 idle after STOP ignores data", a, 0);
      do_stop;

      chk("R11 enable changed only while SCL low", r11_bad, 0);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule